// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block derives bit-timing enables for a serial transmitter and a serial receiver from one fixed reference clock of nominally 5.0688 MHz. A 4-bit rate code picks one of sixteen integer divisors. Dividing the reference by that divisor gives a sampling tick at sixteen times the baud rate. A further divide-by-16 stage gives a 1x baud tick and a square-wave clock for the clock pins. All logic runs on the reference clock, and every timing output is a single-cycle enable pulse.

Each direction picks its own clock source. With the internal source, the direction takes its timing from the divider and drives its clock pin as an output at 1x the baud rate. In asynchronous formats the rate factor is then 16x, whatever the format field asks for. With the external source, the direction's clock pin is an input. Its rising edges are synchronized into the reference domain and divided by 1, 16 or 64, according to the format field. The serializers that use these enables are outside the block.

The select inputs (rate code, source bits, format field) are registered once and take effect one cycle after they change.

Top module: `brg_clockgen`

## Requirements
- R1: Once reset is released, both directions use the external source, and all enables, clock-pin outputs and clock-pin output enables are low until an input edge or a select change arrives.
- R2: For an internal-source direction in an asynchronous format, `*_samp_en` pulses for one cycle every N reference cycles. N depends on the rate code 0..15 as follows: 6336, 4224, 2880, 2355, 2112, 1056, 528, 264, 176, 158, 132, 88, 66, 44, 33, 16. These codes give 50, 75, 110, 134.5, 150, 300, 600, 1200, 1800, 2000, 2400, 3600, 4800, 7200, 9600 and 19,200 baud.
- R3: A new rate code does not cut short the interval in progress. That interval ends at the old divisor, and the interval after it uses the new divisor.
- R4: A direction that uses the internal source has its `*_clk_oe` high. Its `*_clk_out` is a square wave that is low for 8 sampling ticks and then high for 8 sampling ticks (128 and 128 reference cycles at code 15).
- R5: An internal-source direction in an asynchronous format (format field 01, 10 or 11) gives one `*_bit_en` every 16 `*_samp_en` pulses, for every one of those codes.
- R6: An internal-source direction in synchronous format (format field 00) runs at 1x. Its `*_samp_en` and `*_bit_en` pulse together, once every 16 divisor periods.
- R7: An external-source direction gives one `*_samp_en` per rising edge of its clock input. It gives one `*_bit_en` every 1, 16 or 64 rising edges, for format field 01, 10 or 11.
- R8: An external-source direction in synchronous format (field 00) gives one `*_bit_en` per rising edge of its clock input.
- R9: An external-source direction keeps `*_clk_oe` and `*_clk_out` low. The clock input of an internal-source direction has no effect on that direction's timing.
- R10: The transmitter and the receiver pick their sources independently (source bit 1 = internal, 0 = external), and each direction's timing follows only its own choice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 4 | Rate code, 0..15 |
| tx_clk_int | input | 1 | Transmit source: 1 internal, 0 external |
| rx_clk_int | input | 1 | Receive source: 1 internal, 0 external |
| fmt_sel | input | 2 | 00 sync 1x, 01 async 1x, 10 async 16x, 11 async 64x |
| tx_clk_in | input | 1 | External transmit clock |
| rx_clk_in | input | 1 | External receive clock |
| tx_samp_en | output | 1 | Transmit sampling tick |
| tx_bit_en | output | 1 | Transmit bit-time tick |
| rx_samp_en | output | 1 | Receive sampling tick |
| rx_bit_en | output | 1 | Receive bit-time tick |
| tx_clk_out | output | 1 | 1x clock driven onto the transmit clock pin |
| tx_clk_oe | output | 1 | Transmit clock pin driven as output |
| rx_clk_out | output | 1 | 1x clock driven onto the receive clock pin |
| rx_clk_oe | output | 1 | Receive clock pin driven as output |

## Verification
The assertions assume that each external clock input stays at each level for longer than the synchronizer depth. Under that assumption every rising edge becomes exactly one edge pulse. The bench holds each level for three reference cycles. The assertions also assume that the select inputs change only while reset is released. The bench changes a format or source only with the external clock held low. Before it counts any edges, it parks the direction briefly on the internal source, which empties the prescaler, so each count starts from a known phase.

// File: rtl/brg_pkg.sv
package brg_pkg;

  localparam int RATE_W = 4;
  localparam int DIV_W  = 13;
  localparam int PRE_W  = 7;
  localparam int SUB_W  = 4;

  typedef enum logic [1:0] {
    FMT_SYNC  = 2'b00,
    FMT_AX1   = 2'b01,
    FMT_AX16  = 2'b10,
    FMT_AX64  = 2'b11
  } fmt_e;

  // Reference cycles per 16x sampling tick for each rate code.
  function automatic logic [DIV_W-1:0] rate_divisor(input logic [RATE_W-1:0] code);
    logic [DIV_W-1:0] d;
    case (code)
      4'd0:    d = DIV_W'(6336);
      4'd1:    d = DIV_W'(4224);
      4'd2:    d = DIV_W'(2880);
      4'd3:    d = DIV_W'(2355);
      4'd4:    d = DIV_W'(2112);
      4'd5:    d = DIV_W'(1056);
      4'd6:    d = DIV_W'(528);
      4'd7:    d = DIV_W'(264);
      4'd8:    d = DIV_W'(176);
      4'd9:    d = DIV_W'(158);
      4'd10:   d = DIV_W'(132);
      4'd11:   d = DIV_W'(88);
      4'd12:   d = DIV_W'(66);
      4'd13:   d = DIV_W'(44);
      4'd14:   d = DIV_W'(33);
      default: d = DIV_W'(16);
    endcase
    return d;
  endfunction

  // External-clock edges per bit time.
  function automatic logic [PRE_W-1:0] fmt_factor(input fmt_e f);
    logic [PRE_W-1:0] n;
    case (f)
      FMT_AX16: n = PRE_W'(16);
      FMT_AX64: n = PRE_W'(64);
      default:  n = PRE_W'(1);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/brg_divider.sv
module brg_divider
  import brg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_code,
  output logic              tick
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             term;

  assign term = (cnt_q == div_q - ONE);
  assign tick = term;

  always_comb begin
    cnt_d = cnt_q;
    div_d = div_q;
    if (term) begin
      cnt_d = '0;
      div_d = rate_divisor(rate_code);
    end else begin
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= rate_divisor('0);
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_d;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < div_q); // R2
  AST_DIV_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    !term |=> $stable(div_q)); // R3

endmodule

// File: rtl/brg_x1_gen.sv
module brg_x1_gen
  import brg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick16,
  output logic tick1x,
  output logic clk1x
);

  localparam logic [SUB_W-1:0] ONE = SUB_W'(1);

  logic [SUB_W-1:0] sub_q, sub_d;

  always_comb begin
    sub_d = sub_q;
    if (tick16) sub_d = sub_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sub_q <= '0;
    else        sub_q <= sub_d;
  end

  assign tick1x = tick16 && (sub_q == '1);
  assign clk1x  = sub_q[SUB_W-1];

  AST_PIN_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    !tick16 |=> $stable(clk1x)); // R4

endmodule

// File: rtl/brg_dir_path.sv
module brg_dir_path
  import brg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic use_int,
  input  fmt_e fmt,
  input  logic ext_clk,
  input  logic tick16,
  input  logic tick1x,
  input  logic clk1x,
  output logic samp_en,
  output logic bit_en,
  output logic pin_out,
  output logic pin_oe
);

  localparam int SH_W = SYNC_STAGES + 1;
  localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

  logic [SH_W-1:0]  sync_q, sync_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] factor;
  logic             rise, ext_bit;

  assign sync_d  = {sync_q[SH_W-2:0], ext_clk};
  assign rise    = sync_q[SH_W-2] && !sync_q[SH_W-1];
  assign factor  = fmt_factor(fmt);
  assign ext_bit = rise && (pre_q >= factor - ONE);

  always_comb begin
    pre_d = pre_q;
    if (use_int)      pre_d = '0;
    else if (ext_bit) pre_d = '0;
    else if (rise)    pre_d = pre_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      pre_q  <= '0;
    end else begin
      sync_q <= sync_d;
      pre_q  <= pre_d;
    end
  end

  always_comb begin
    if (use_int) begin
      samp_en = (fmt == FMT_SYNC) ? tick1x : tick16;
      bit_en  = tick1x;
      pin_out = clk1x;
      pin_oe  = 1'b1;
    end else begin
      samp_en = rise;
      bit_en  = ext_bit;
      pin_out = 1'b0;
      pin_oe  = 1'b0;
    end
  end

  AST_BIT_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |-> samp_en); // R5
  AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !use_int |-> (pre_q < factor)); // R7
  AST_EXT_SAMPLE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_int && samp_en) |-> (sync_q[SH_W-2] && !sync_q[SH_W-1])); // R9

endmodule

// File: rtl/brg_clockgen.sv
module brg_clockgen
  import brg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              tx_clk_int,
  input  logic              rx_clk_int,
  input  logic [1:0]        fmt_sel,
  input  logic              tx_clk_in,
  input  logic              rx_clk_in,
  output logic              tx_samp_en,
  output logic              tx_bit_en,
  output logic              rx_samp_en,
  output logic              rx_bit_en,
  output logic              tx_clk_out,
  output logic              tx_clk_oe,
  output logic              rx_clk_out,
  output logic              rx_clk_oe
);

  localparam int NDIR = 2;  // index 0 transmit, 1 receive

  logic [RATE_W-1:0] rate_q;
  logic [NDIR-1:0]   int_q, int_d;
  fmt_e              fmt_q;
  logic              tick16, tick1x, clk1x;
  logic [NDIR-1:0]   ext_v, samp_v, bit_v, pin_v, oe_v;

  assign int_d = {rx_clk_int, tx_clk_int};

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      int_q  <= '0;
      fmt_q  <= FMT_SYNC;
    end else begin
      rate_q <= rate_sel;
      int_q  <= int_d;
      fmt_q  <= fmt_e'(fmt_sel);
    end
  end

  brg_divider u_div (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .rate_code (rate_q),
    .tick      (tick16)
  );

  brg_x1_gen u_x1 (
    .clk    (clk_ref),
    .rst_n  (rst_n),
    .tick16 (tick16),
    .tick1x (tick1x),
    .clk1x  (clk1x)
  );

  assign ext_v = {rx_clk_in, tx_clk_in};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    brg_dir_path #(.SYNC_STAGES(SYNC_STAGES)) u_path (
      .clk     (clk_ref),
      .rst_n   (rst_n),
      .use_int (int_q[d]),
      .fmt     (fmt_q),
      .ext_clk (ext_v[d]),
      .tick16  (tick16),
      .tick1x  (tick1x),
      .clk1x   (clk1x),
      .samp_en (samp_v[d]),
      .bit_en  (bit_v[d]),
      .pin_out (pin_v[d]),
      .pin_oe  (oe_v[d])
    );
  end

  assign tx_samp_en = samp_v[0];
  assign tx_bit_en  = bit_v[0];
  assign tx_clk_out = pin_v[0];
  assign tx_clk_oe  = oe_v[0];
  assign rx_samp_en = samp_v[1];
  assign rx_bit_en  = bit_v[1];
  assign rx_clk_out = pin_v[1];
  assign rx_clk_oe  = oe_v[1];

  AST_SYNC_INT_LOCKSTEP: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (int_q[1] && fmt_q == FMT_SYNC) |-> (rx_samp_en == rx_bit_en)); // R6
  AST_EXT_PIN_QUIET: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !int_q[0] |-> (!tx_clk_oe && !tx_clk_out)); // R9

endmodule

// File: tb/brg_clockgen_tb_top.sv
module brg_clockgen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 190000;
  localparam int EXP_DIV [16] = '{6336, 4224, 2880, 2355, 2112, 1056, 528, 264,
                                  176, 158, 132, 88, 66, 44, 33, 16};

  logic       clk_ref = 1'b0;
  logic       rst_n;
  logic [3:0] rate_sel;
  logic       tx_clk_int, rx_clk_int;
  logic [1:0] fmt_sel;
  logic       tx_clk_in, rx_clk_in;
  logic       tx_samp_en, tx_bit_en, rx_samp_en, rx_bit_en;
  logic       tx_clk_out, tx_clk_oe, rx_clk_out, rx_clk_oe;

  int n_chk = 0;
  int n_bad = 0;
  int rs_cnt = 0, rb_cnt = 0;

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  brg_clockgen dut_i (
    .clk_ref, .rst_n, .rate_sel, .tx_clk_int, .rx_clk_int, .fmt_sel,
    .tx_clk_in, .rx_clk_in, .tx_samp_en, .tx_bit_en, .rx_samp_en, .rx_bit_en,
    .tx_clk_out, .tx_clk_oe, .rx_clk_out, .rx_clk_oe
  );

  always @(negedge clk_ref) begin
    if (rx_samp_en) rs_cnt++;
    if (rx_bit_en)  rb_cnt++;
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int s);
    case (s)
      0: return rx_samp_en;
      1: return rx_bit_en;
      2: return tx_samp_en;
      default: return tx_bit_en;
    endcase
  endfunction

  task automatic wait_pulse(input int s);
    int k = 0;
    do begin @(negedge clk_ref); k++; end while (!pick(s) && k < 20000);
  endtask

  // Cycles between the pulse just seen and the next one.
  task automatic gap(input int s, output int n);
    n = 0;
    do begin @(negedge clk_ref); n++; end while (!pick(s) && n < 20000);
  endtask

  task automatic rx_edges(input int n);
    for (int i = 0; i < n; i++) begin
      rx_clk_in = 1'b1; repeat (3) @(negedge clk_ref);
      rx_clk_in = 1'b0; repeat (3) @(negedge clk_ref);
    end
    repeat (6) @(negedge clk_ref);
  endtask

  task automatic ext_count(input logic [1:0] f, input int edges, output int ds, output int db);
    int s0, b0;
    rx_clk_int = 1'b1; fmt_sel = f;
    repeat (4) @(negedge clk_ref);
    rx_clk_int = 1'b0;
    repeat (4) @(negedge clk_ref);
    s0 = rs_cnt; b0 = rb_cnt;
    rx_edges(edges);
    ds = rs_cnt - s0; db = rb_cnt - b0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk_ref);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
    summary();
    $finish;
  end

  initial begin
    int g, g2, hi, lo, ds, db, mism;
    rst_n = 1'b0; rate_sel = 4'd0; tx_clk_int = 1'b0; rx_clk_int = 1'b0;
    fmt_sel = 2'b00; tx_clk_in = 1'b0; rx_clk_in = 1'b0;
    repeat (5) @(negedge clk_ref);
    rst_n = 1'b1;
    repeat (3) @(negedge clk_ref);
    // R1 reset state
    check("R1 outputs", {28'd0, tx_samp_en, tx_bit_en, rx_samp_en, rx_bit_en}, 0);
    check("R1 pins", {28'd0, tx_clk_out, tx_clk_oe, rx_clk_out, rx_clk_oe}, 0);

    // R2 divisor table walk, internal async 16x on the receiver
    rx_clk_int = 1'b1; fmt_sel = 2'b10;
    for (int i = 15; i >= 0; i--) begin
      rate_sel = 4'(i);
      wait_pulse(0); wait_pulse(0);
      gap(0, g);
      check($sformatf("R2 code %0d", i), g, EXP_DIV[i]);
    end

    // R3 rate change mid-period
    rate_sel = 4'd15;
    wait_pulse(0); wait_pulse(0); wait_pulse(0);
    fork
      begin repeat (5) @(negedge clk_ref); rate_sel = 4'd14; end
      gap(0, g);
    join
    gap(0, g2);
    check("R3 old interval", g, 16);
    check("R3 new interval", g2, 33);

    // R4 1x pin at code 15
    rate_sel = 4'd15;
    repeat (600) @(negedge clk_ref);
    check("R4 oe", rx_clk_oe, 1);
    while (rx_clk_out) @(negedge clk_ref);
    while (!rx_clk_out) @(negedge clk_ref);
    hi = 0; while (rx_clk_out) begin hi++; @(negedge clk_ref); end
    lo = 0; while (!rx_clk_out) begin lo++; @(negedge clk_ref); end
    check("R4 high", hi, 128);
    check("R4 low", lo, 128);

    // R5 16 samples per bit under every async field
    for (int f = 1; f < 4; f++) begin
      fmt_sel = 2'(f);
      repeat (3) @(negedge clk_ref);
      wait_pulse(1);
      ds = rs_cnt;
      gap(1, g);
      check($sformatf("R5 bit gap fmt %0d", f), g, 256);
      check($sformatf("R5 samples fmt %0d", f), rs_cnt - ds, 16);
    end

    // R6 internal sync runs at 1x
    fmt_sel = 2'b00;
    repeat (3) @(negedge clk_ref);
    wait_pulse(0);
    gap(0, g);
    check("R6 sample gap", g, 256);
    mism = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk_ref);
      if (rx_samp_en != rx_bit_en) mism++;
    end
    check("R6 lockstep", mism, 0);

    // R7 external factors; R8 external sync
    ext_count(2'b01, 10, ds, db);
    check("R7 x1 samples", ds, 10);
    check("R7 x1 bits", db, 10);
    ext_count(2'b10, 64, ds, db);
    check("R7 x16 samples", ds, 64);
    check("R7 x16 bits", db, 4);
    ext_count(2'b11, 128, ds, db);
    check("R7 x64 samples", ds, 128);
    check("R7 x64 bits", db, 2);
    ext_count(2'b00, 12, ds, db);
    check("R8 sync samples", ds, 12);
    check("R8 sync bits", db, 12);

    // R9 external pin quiet; internal ignores its clock input
    check("R9 ext oe", rx_clk_oe, 0);
    check("R9 ext out", rx_clk_out, 0);
    fmt_sel = 2'b10; rate_sel = 4'd15; tx_clk_int = 1'b1;
    repeat (4) @(negedge clk_ref);
    fork
      begin
        for (int i = 0; i < 200; i++) begin @(negedge clk_ref); tx_clk_in = ~tx_clk_in; end
        tx_clk_in = 1'b0;
      end
      begin wait_pulse(2); gap(2, g); gap(2, g2); end
    join
    check("R9 int gap a", g, 16);
    check("R9 int gap b", g2, 16);

    // R10 tx internal, rx external at once
    fmt_sel = 2'b01;
    repeat (4) @(negedge clk_ref);
    ds = rs_cnt;
    rx_edges(10);
    check("R10 rx edges", rs_cnt - ds, 10);
    check("R10 pin oe", {30'd0, tx_clk_oe, rx_clk_oe}, 2);
    wait_pulse(2); gap(2, g);
    check("R10 tx gap", g, 16);

    summary();
    $finish;
  end

endmodule